// File: doc/BRIEF.md
# Mailbox Command Dispatcher

This block sits behind the host-visible mailbox of a memory-expansion device. The host first loads a command register with three fields: a command-set byte, a command byte and a payload length. It then rings a doorbell. The dispatcher forms a 16-bit opcode, with the set byte in the upper half and the command byte in the lower half. It looks that opcode up in a fixed table of supported commands. It then checks the supplied length against the input length the command expects. Only a command that passes both checks is handed to an external handler, through a start pulse.

When the handler answers with a done pulse, the dispatcher writes the handler's return code into the status register. It zeroes the set and command fields, loads the length field with the handler's output length, and drops the doorbell in the same cycle. A command that fails either check never reaches the handler. It completes with its own return code and an output length of zero. Only one command is outstanding at a time.

Top module: `mbx_dispatch`

## Requirements
- R1: For a supported opcode with an acceptable length, exactly one single-cycle `hdl_start` pulse is issued. While it is high, `hdl_opcode` equals {set byte, command byte} and `hdl_in_len` equals the supplied length. The pulse never comes in the first busy cycle.
- R2: An opcode that is not in the table completes with return code 0x03, an output length of 0, and no start pulse.
- R3: A supported fixed-length opcode whose supplied length differs from its expected length completes with return code 0x16, an output length of 0, and no start pulse. The expected lengths include 8 for opcode 0x0301, 0x18 for 0x0401, 4 for 0x0103, and 0 for 0x4000 and 0x0200.
- R4: Opcodes 0x0101 and 0x4103 accept any supplied length, including 0.
- R5: On completion of a dispatched command, `sts_rc` equals the handler's return code and `reg_len` equals the handler's output length. `reg_set` and `reg_cmd` both read 0.
- R6: `db_busy` is 1 from the clock edge after the ring until the edge at which the completion values appear. It falls at that same edge.
- R7: A doorbell ring while `db_busy` is 1 is ignored: no further start pulse occurs, and the block is idle afterwards.
- R8: Command-register writes while `db_busy` is 1 are ignored. The opcode and length given to the handler are the ones written before the ring.
- R9: After reset `db_busy`, `reg_set`, `reg_cmd`, `reg_len` and `sts_rc` are all 0, and `hdl_start` is 0.
- R10: Return codes are 8 bits wide: 0x00 success, 0x01 background started, 0x02 invalid input, 0x03 unsupported, 0x04 internal error, 0x05 retry, 0x06 busy, 0x16 invalid payload length. The handler's code passes through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_wr | input | 1 | Write strobe for the command register |
| wr_set | input | 8 | Command-set byte to write |
| wr_cmd | input | 8 | Command byte to write |
| wr_len | input | LEN_W | Payload length to write |
| db_ring | input | 1 | Doorbell ring request |
| db_busy | output | 1 | Doorbell bit; high while a command is in flight |
| reg_set | output | 8 | Command-set field of the command register |
| reg_cmd | output | 8 | Command field of the command register |
| reg_len | output | LEN_W | Length field of the command register |
| sts_rc | output | 8 | Return-code field of the status register |
| hdl_start | output | 1 | One-cycle request to the handler |
| hdl_opcode | output | 16 | Opcode given to the handler |
| hdl_in_len | output | LEN_W | Input length given to the handler |
| hdl_done | input | 1 | Handler completion pulse |
| hdl_rc | input | 8 | Handler return code, valid with hdl_done |
| hdl_out_len | input | LEN_W | Handler output length, valid with hdl_done |

## Verification
The assertions assume the handler behaves in a fixed way. It raises `hdl_done` only while a dispatched command is executing, and then only once per start. Its output length never exceeds the configured payload buffer size. The stimulus drives `hdl_done` only after it has seen `hdl_start`. It drives the pulse for exactly one cycle, and every output length it supplies fits within the buffer.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam int OP_W = 16;
    localparam int RC_W = 8;

    typedef enum logic [RC_W-1:0] {
        RC_OK        = 8'h00,
        RC_BG        = 8'h01,
        RC_BAD_INPUT = 8'h02,
        RC_UNSUP     = 8'h03,
        RC_INTERNAL  = 8'h04,
        RC_RETRY     = 8'h05,
        RC_BUSY      = 8'h06,
        RC_BAD_LEN   = 8'h16,
        RC_LIMIT     = 8'h17
    } mbx_rc_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CHECK = 2'd1,
        ST_EXEC  = 2'd2,
        ST_DONE  = 2'd3
    } mbx_state_e;

    typedef struct packed {
        logic [OP_W-1:0] op;
        logic            any_len;
        logic [7:0]      in_len;
    } cmd_ent_t;

    localparam int N_CMDS = 13;

    // opcode, accepts any length, expected input length
    localparam cmd_ent_t CMD_TBL [N_CMDS] = '{
        '{16'h4103, 1'b1, 8'h00},
        '{16'h4102, 1'b0, 8'h00},
        '{16'h4100, 1'b0, 8'h00},
        '{16'h4000, 1'b0, 8'h00},
        '{16'h0401, 1'b0, 8'h18},
        '{16'h0400, 1'b0, 8'h00},
        '{16'h0301, 1'b0, 8'h08},
        '{16'h0300, 1'b0, 8'h00},
        '{16'h0200, 1'b0, 8'h00},
        '{16'h0103, 1'b0, 8'h04},
        '{16'h0102, 1'b0, 8'h00},
        '{16'h0101, 1'b1, 8'h00},
        '{16'h0100, 1'b0, 8'h01}
    };

endpackage

// File: rtl/mbx_cmd_table.sv
module mbx_cmd_table
    import mbx_pkg::*;
(
    input  logic [OP_W-1:0] opcode,
    output logic            hit,
    output logic            any_len,
    output logic [7:0]      exp_len
);

    logic [N_CMDS-1:0] match;

    generate
        for (genvar i = 0; i < N_CMDS; i++) begin : g_ent
            assign match[i] = (opcode == CMD_TBL[i].op);
        end
    endgenerate

    always_comb begin
        hit     = |match;
        any_len = 1'b0;
        exp_len = '0;
        for (int i = 0; i < N_CMDS; i++) begin
            if (match[i]) begin
                any_len = CMD_TBL[i].any_len;
                exp_len = CMD_TBL[i].in_len;
            end
        end
    end

endmodule

// File: rtl/mbx_len_check.sv
module mbx_len_check #(
    parameter int LEN_W = 16
) (
    input  logic             any_len,
    input  logic [7:0]       exp_len,
    input  logic [LEN_W-1:0] len,
    output logic             len_ok
);

    logic [LEN_W-1:0] exp_ext;

    always_comb begin
        exp_ext = LEN_W'(exp_len);
        len_ok  = any_len || (len == exp_ext);
    end

endmodule

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
    import mbx_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_wr,
    input  logic [7:0]       wr_set,
    input  logic [7:0]       wr_cmd,
    input  logic [LEN_W-1:0] wr_len,
    input  logic             db_ring,
    input  logic             hit,
    input  logic             len_ok,
    input  logic             hdl_done,
    input  logic [RC_W-1:0]  hdl_rc,
    input  logic [LEN_W-1:0] hdl_out_len,
    output logic             db_busy,
    output logic [7:0]       reg_set,
    output logic [7:0]       reg_cmd,
    output logic [LEN_W-1:0] reg_len,
    output logic [RC_W-1:0]  sts_rc,
    output logic             hdl_start
);

    typedef struct packed {
        mbx_state_e       st;
        logic             busy;
        logic [7:0]       set;
        logic [7:0]       cmd;
        logic [LEN_W-1:0] len;
        logic [RC_W-1:0]  rc;
        logic             start;
        logic [RC_W-1:0]  cap_rc;
        logic [LEN_W-1:0] cap_len;
    } ctrl_t;

    ctrl_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.start = 1'b0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (cmd_wr) begin
                    s_d.set = wr_set;
                    s_d.cmd = wr_cmd;
                    s_d.len = wr_len;
                end
                if (db_ring) begin
                    s_d.busy = 1'b1;
                    s_d.st   = ST_CHECK;
                end
            end
            ST_CHECK: begin
                if (!hit) begin
                    s_d.cap_rc  = RC_UNSUP;
                    s_d.cap_len = '0;
                    s_d.st      = ST_DONE;
                end else if (!len_ok) begin
                    s_d.cap_rc  = RC_BAD_LEN;
                    s_d.cap_len = '0;
                    s_d.st      = ST_DONE;
                end else begin
                    s_d.start = 1'b1;
                    s_d.st    = ST_EXEC;
                end
            end
            ST_EXEC: begin
                if (hdl_done) begin
                    s_d.cap_rc  = hdl_rc;
                    s_d.cap_len = hdl_out_len;
                    s_d.st      = ST_DONE;
                end
            end
            ST_DONE: begin
                s_d.rc   = s_q.cap_rc;
                s_d.len  = s_q.cap_len;
                s_d.set  = '0;
                s_d.cmd  = '0;
                s_d.busy = 1'b0;
                s_d.st   = ST_IDLE;
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign db_busy   = s_q.busy;
    assign reg_set   = s_q.set;
    assign reg_cmd   = s_q.cmd;
    assign reg_len   = s_q.len;
    assign sts_rc    = s_q.rc;
    assign hdl_start = s_q.start;

endmodule

// File: rtl/mbx_dispatch.sv
module mbx_dispatch
    import mbx_pkg::*;
#(
    parameter int LEN_W       = 16,
    parameter int PAYLOAD_MAX = 512
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_wr,
    input  logic [7:0]       wr_set,
    input  logic [7:0]       wr_cmd,
    input  logic [LEN_W-1:0] wr_len,
    input  logic             db_ring,
    output logic             db_busy,
    output logic [7:0]       reg_set,
    output logic [7:0]       reg_cmd,
    output logic [LEN_W-1:0] reg_len,
    output logic [7:0]       sts_rc,
    output logic             hdl_start,
    output logic [15:0]      hdl_opcode,
    output logic [LEN_W-1:0] hdl_in_len,
    input  logic             hdl_done,
    input  logic [7:0]       hdl_rc,
    input  logic [LEN_W-1:0] hdl_out_len
);

    logic       hit;
    logic       any_len;
    logic [7:0] exp_len;
    logic       len_ok;

    mbx_cmd_table u_tbl (
        .opcode  ({reg_set, reg_cmd}),
        .hit     (hit),
        .any_len (any_len),
        .exp_len (exp_len)
    );

    mbx_len_check #(.LEN_W(LEN_W)) u_len (
        .any_len (any_len),
        .exp_len (exp_len),
        .len     (reg_len),
        .len_ok  (len_ok)
    );

    mbx_ctrl #(.LEN_W(LEN_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_wr      (cmd_wr),
        .wr_set      (wr_set),
        .wr_cmd      (wr_cmd),
        .wr_len      (wr_len),
        .db_ring     (db_ring),
        .hit         (hit),
        .len_ok      (len_ok),
        .hdl_done    (hdl_done),
        .hdl_rc      (hdl_rc),
        .hdl_out_len (hdl_out_len),
        .db_busy     (db_busy),
        .reg_set     (reg_set),
        .reg_cmd     (reg_cmd),
        .reg_len     (reg_len),
        .sts_rc      (sts_rc),
        .hdl_start   (hdl_start)
    );

    assign hdl_opcode = {reg_set, reg_cmd};
    assign hdl_in_len = reg_len;

endmodule

// File: rtl/mbx_dispatch_chk.sv
module mbx_dispatch_chk #(
    parameter int LEN_W       = 16,
    parameter int PAYLOAD_MAX = 512
) (
    input logic             clk,
    input logic             rst_n,
    input logic             db_busy,
    input logic [7:0]       reg_set,
    input logic [7:0]       reg_cmd,
    input logic [LEN_W-1:0] reg_len,
    input logic             hdl_start,
    input logic             hdl_done,
    input logic [LEN_W-1:0] hdl_out_len
);

    // R1
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hdl_start |=> !hdl_start);

    // R1
    start_late_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hdl_start |-> (db_busy && $past(db_busy)));

    // R5
    done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(db_busy) |-> (reg_set == 8'h00 && reg_cmd == 8'h00));

    // R8
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (db_busy && $past(db_busy)) |->
            ($stable(reg_set) && $stable(reg_cmd) && $stable(reg_len)));

    // R6
    idle_nostart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !db_busy |-> !hdl_start);

    // R5
    out_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hdl_done |-> (int'(hdl_out_len) <= PAYLOAD_MAX));

endmodule

bind mbx_dispatch mbx_dispatch_chk #(.LEN_W(LEN_W), .PAYLOAD_MAX(PAYLOAD_MAX)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .db_busy     (db_busy),
    .reg_set     (reg_set),
    .reg_cmd     (reg_cmd),
    .reg_len     (reg_len),
    .hdl_start   (hdl_start),
    .hdl_done    (hdl_done),
    .hdl_out_len (hdl_out_len)
);

// File: tb/mbx_dispatch_tb.sv
module mbx_dispatch_tb;

    localparam int LEN_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cmd_wr = 1'b0;
    logic [7:0]       wr_set = '0;
    logic [7:0]       wr_cmd = '0;
    logic [LEN_W-1:0] wr_len = '0;
    logic             db_ring = 1'b0;
    logic             db_busy;
    logic [7:0]       reg_set, reg_cmd, sts_rc;
    logic [LEN_W-1:0] reg_len, hdl_in_len;
    logic             hdl_start;
    logic [15:0]      hdl_opcode;
    logic             hdl_done = 1'b0;
    logic [7:0]       hdl_rc = '0;
    logic [LEN_W-1:0] hdl_out_len = '0;

    int errors = 0;
    int checks = 0;
    int n_start;
    logic [15:0]      got_op;
    logic [LEN_W-1:0] got_len;
    logic             busy_early;
    logic             idle_after;

    always #5 clk = ~clk;

    mbx_dispatch #(.LEN_W(LEN_W), .PAYLOAD_MAX(512)) u_dut (.*);

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Issue one command and play the handler; poke drives rings and writes while busy.
    task automatic run_cmd(input logic [7:0] s, input logic [7:0] c, input logic [LEN_W-1:0] l,
                           input logic [7:0] rc, input logic [LEN_W-1:0] ol,
                           input int dly, input bit poke);
        int cnt = -1;
        @(negedge clk);
        cmd_wr = 1'b1; wr_set = s; wr_cmd = c; wr_len = l;
        @(negedge clk);
        cmd_wr = 1'b0; db_ring = 1'b1;
        @(negedge clk);
        db_ring = 1'b0;
        busy_early = db_busy;
        n_start = 0;
        got_op = '0;
        got_len = '0;
        for (int i = 0; i < 100; i++) begin
            if (poke) begin
                db_ring = 1'b1; cmd_wr = 1'b1;
                wr_set = 8'hAA; wr_cmd = 8'h55; wr_len = 16'h0077;
            end
            if (hdl_start) begin
                n_start++;
                got_op = hdl_opcode;
                got_len = hdl_in_len;
                cnt = dly;
            end
            if (cnt == 0) begin
                hdl_done = 1'b1; hdl_rc = rc; hdl_out_len = ol;
            end else begin
                hdl_done = 1'b0;
            end
            if (cnt >= 0) cnt--;
            @(negedge clk);
            if (!db_busy) break;
        end
        db_ring = 1'b0; cmd_wr = 1'b0; hdl_done = 1'b0;
        repeat (3) @(negedge clk);
        idle_after = !db_busy && !hdl_start;
    endtask

    task automatic t_reset;
        check(db_busy == 1'b0, "R9 busy", db_busy, 0);
        check(reg_set == 8'h00 && reg_cmd == 8'h00, "R9 set/cmd", {reg_set, reg_cmd}, 0);
        check(reg_len == '0, "R9 len", reg_len, 0);
        check(sts_rc == 8'h00, "R9 rc", sts_rc, 0);
        check(hdl_start == 1'b0, "R9 start", hdl_start, 0);
    endtask

    task automatic t_unsupported;
        run_cmd(8'h05, 8'h00, 16'h0000, 8'h00, 16'h0000, 0, 1'b0);
        check(n_start == 0, "R2 no start", n_start, 0);
        check(sts_rc == 8'h03, "R2 rc", sts_rc, 8'h03);
        check(reg_len == '0, "R2 len", reg_len, 0);
        run_cmd(8'h41, 8'h01, 16'h0000, 8'h00, 16'h0000, 0, 1'b0);
        check(n_start == 0 && sts_rc == 8'h03, "R2 gap opcode 0x4101", sts_rc, 8'h03);
    endtask

    task automatic t_bad_len;
        run_cmd(8'h03, 8'h01, 16'h0004, 8'h00, 16'h0000, 0, 1'b0);
        check(n_start == 0, "R3 no start", n_start, 0);
        check(sts_rc == 8'h16, "R3 rc 0x0301", sts_rc, 8'h16);
        check(reg_len == '0, "R3 len", reg_len, 0);
        run_cmd(8'h40, 8'h00, 16'h0001, 8'h00, 16'h0000, 0, 1'b0);
        check(sts_rc == 8'h16 && n_start == 0, "R3 rc 0x4000", sts_rc, 8'h16);
        run_cmd(8'h01, 8'h03, 16'h0008, 8'h00, 16'h0000, 0, 1'b0);
        check(sts_rc == 8'h16 && n_start == 0, "R3 rc 0x0103", sts_rc, 8'h16);
    endtask

    task automatic t_fixed_ok;
        run_cmd(8'h03, 8'h01, 16'h0008, 8'h00, 16'h0000, 0, 1'b0);
        check(n_start == 1, "R1 one start", n_start, 1);
        check(got_op == 16'h0301, "R1 opcode", got_op, 16'h0301);
        check(got_len == 16'h0008, "R1 in_len", got_len, 8);
        check(busy_early == 1'b1, "R6 busy after ring", busy_early, 1);
        check(sts_rc == 8'h00 && reg_len == '0, "R5 ts set", sts_rc, 0);
        run_cmd(8'h04, 8'h01, 16'h0018, 8'h00, 16'h0040, 3, 1'b0);
        check(got_op == 16'h0401 && n_start == 1, "R1 get log opcode", got_op, 16'h0401);
        check(reg_len == 16'h0040, "R5 out len", reg_len, 16'h0040);
        check(reg_set == 8'h00 && reg_cmd == 8'h00, "R5 fields cleared", {reg_set, reg_cmd}, 0);
        check(db_busy == 1'b0, "R6 busy cleared", db_busy, 0);
        run_cmd(8'h40, 8'h00, 16'h0000, 8'h04, 16'h0000, 1, 1'b0);
        check(sts_rc == 8'h04, "R10 handler rc passthrough", sts_rc, 8'h04);
        run_cmd(8'h02, 8'h00, 16'h0000, 8'h01, 16'h0050, 2, 1'b0);
        check(sts_rc == 8'h01 && reg_len == 16'h0050, "R10 bg code and len", sts_rc, 8'h01);
    endtask

    task automatic t_var_len;
        run_cmd(8'h41, 8'h03, 16'h0123, 8'h00, 16'h0000, 0, 1'b0);
        check(n_start == 1 && got_len == 16'h0123, "R4 0x4103 any len", got_len, 16'h0123);
        check(sts_rc == 8'h00, "R4 rc", sts_rc, 0);
        run_cmd(8'h01, 8'h01, 16'h0000, 8'h00, 16'h0000, 0, 1'b0);
        check(n_start == 1 && got_op == 16'h0101, "R4 0x0101 zero len", got_op, 16'h0101);
    endtask

    task automatic t_busy_pokes;
        run_cmd(8'h03, 8'h01, 16'h0008, 8'h00, 16'h0010, 4, 1'b1);
        check(n_start == 1, "R7 ring while busy ignored", n_start, 1);
        check(got_op == 16'h0301 && got_len == 16'h0008, "R8 writes while busy ignored", got_op, 16'h0301);
        check(reg_len == 16'h0010 && reg_set == 8'h00, "R8 completion regs", reg_len, 16'h0010);
        check(idle_after == 1'b1, "R7 idle after", idle_after, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_unsupported();
        t_bad_len();
        t_fixed_ok();
        t_var_len();
        t_busy_pokes();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule